// File: doc/BRIEF.md
# SIMD Compare and Select Unit

This block is a partitioned vector datapath with two operations. A compare treats two vector operands as a row of integer elements. It writes, for each element, a field that is all ones where the condition holds and all zeros where it does not. A select merges two vector operands bit by bit under a third mask operand. A compare result fed back as the mask of a select replaces branchy scalar code with two straight-line operations. One example is finding the zero bytes of a vector and replacing them with a fill value.

The element width can be 8, 16 or 32 bits. Greater-than compares can be signed or unsigned. A compare can optionally record two summary flags, "every element true" and "every element false", so that software can accept or reject a whole vector with one test. The sources are never overwritten: each operation reads separate source buses and drives a separate result bus. The result is registered, and the block accepts one operation every cycle.

Top module: `simd_cmpsel`

## Requirements
- R1: When `in_op`=0 (compare) and `in_cond`=0 (equal), every element of `out_data` is all ones if the matching elements of `src_a` and `src_b` are equal, and all zeros otherwise.
- R2: When `in_op`=0, `in_cond`=1 (greater-than) and `in_signed`=1, an element is all ones when the `src_a` element exceeds the `src_b` element as a two's-complement number. For example, byte 0x7F is greater than byte 0x80.
- R3: When `in_op`=0, `in_cond`=1 and `in_signed`=0, an element is all ones when the `src_a` element exceeds the `src_b` element as an unsigned number. For example, byte 0x80 is greater than byte 0x7F.
- R4: `in_size` sets the compare element width: 0 is 8 bits (16 elements), 1 is 16 bits (8 elements), 2 is 32 bits (4 elements), and 3 behaves exactly as 2. Element k occupies bits [k*W+W-1 : k*W].
- R5: When `in_op`=1 (select), each bit of `out_data` is the `src_b` bit where the `src_m` bit is 1 and the `src_a` bit where it is 0. `in_size`, `in_cond` and `in_signed` have no effect.
- R6: A compare with `in_rec`=1 sets `out_all_true` to 1 only if every element compared true. It sets `out_all_false` to 1 only if every element compared false. A mixed result clears both flags.
- R7: A select, or a compare with `in_rec`=0, leaves `out_all_true` and `out_all_false` unchanged.
- R8: A result appears on `out_data` with `out_valid`=1 one clock after the operation is presented with `in_valid`=1. A new operation may be presented every cycle. While `in_valid`=0, `out_valid` is 0 the next cycle and `out_data` holds its last value.
- R9: While `rst_n` is low, `out_valid`, `out_data`, `out_all_true` and `out_all_false` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 1 | 0 compare, 1 select |
| in_cond | input | 1 | Compare condition: 0 equal, 1 greater-than |
| in_signed | input | 1 | Greater-than treats elements as signed when 1 |
| in_size | input | 2 | Element width: 0 byte, 1 halfword, 2 or 3 word |
| in_rec | input | 1 | Compare also updates the summary flags |
| src_a | input | VEC_W | First source vector, and the select value taken where the mask is 0 |
| src_b | input | VEC_W | Second source vector, and the select value taken where the mask is 1 |
| src_m | input | VEC_W | Select mask |
| out_valid | output | 1 | Result valid |
| out_data | output | VEC_W | Registered result vector |
| out_all_true | output | 1 | Last recorded compare was true in every element |
| out_all_false | output | 1 | Last recorded compare was false in every element |

## Verification
The bench builds the block with its default vector width of 128 bits. This gives 16, 8 and 4 elements for the three sizes, so the sign bit of every element position and the size-3 alias are all exercised on real lane boundaries. Random operands are drawn with many elements deliberately equal, so that equal, mixed, all-true and all-false outcomes all occur. Directed cases cover signed and unsigned crossings at 0x80/0x7F and flag retention across unrecorded operations.

// File: rtl/simd_cs_pkg.sv
`timescale 1ns/1ps
package simd_cs_pkg;

    typedef enum logic {
        OP_CMP = 1'b0,
        OP_SEL = 1'b1
    } op_e;

    typedef enum logic {
        CND_EQ = 1'b0,
        CND_GT = 1'b1
    } cond_e;

    // Element width choices; the fourth code aliases the widest one.
    localparam int NUM_SIZES  = 3;
    localparam int BASE_EW    = 8;

    function automatic int size_index(input logic [1:0] code);
        return (code == 2'd3) ? 2 : int'(code);
    endfunction

endpackage

// File: rtl/simd_elem_cmp.sv
`timescale 1ns/1ps
// Compares two vectors as VEC_W/EW elements; each element becomes a full mask.
module simd_elem_cmp #(
    parameter int VEC_W = 128,
    parameter int EW    = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             gt_sel,
    input  logic             signed_sel,
    output logic [VEC_W-1:0] mask
);
    localparam int N_EL = VEC_W / EW;

    for (genvar e = 0; e < N_EL; e++) begin : g_el
        localparam int LO = e * EW;
        logic [EW-1:0] ua;
        logic [EW-1:0] ub;
        logic          hit;

        // Flipping the sign bit maps signed order onto unsigned order.
        assign ua  = {a[LO+EW-1] ^ signed_sel, a[LO +: EW-1]};
        assign ub  = {b[LO+EW-1] ^ signed_sel, b[LO +: EW-1]};
        assign hit = gt_sel ? (ua > ub) : (ua == ub);
        assign mask[LO +: EW] = {EW{hit}};
    end
endmodule

// File: rtl/simd_bit_sel.sv
`timescale 1ns/1ps
// Bitwise merge: mask 1 picks from on_set, mask 0 picks from on_clr.
module simd_bit_sel #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] on_clr,
    input  logic [VEC_W-1:0] on_set,
    input  logic [VEC_W-1:0] sel,
    output logic [VEC_W-1:0] y
);
    assign y = (on_set & sel) | (on_clr & ~sel);
endmodule

// File: rtl/simd_mask_summary.sv
`timescale 1ns/1ps
// Reduces a full-width element mask to all-true / all-false summary bits.
module simd_mask_summary #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] mask,
    output logic             all_set,
    output logic             all_clr
);
    assign all_set = &mask;
    assign all_clr = ~|mask;
endmodule

// File: rtl/simd_cmpsel.sv
`timescale 1ns/1ps
module simd_cmpsel
    import simd_cs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic             in_cond,
    input  logic             in_signed,
    input  logic [1:0]       in_size,
    input  logic             in_rec,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] src_m,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             out_all_true,
    output logic             out_all_false
);
    op_e              op;
    cond_e            cond;
    logic [VEC_W-1:0] mask_by_size [NUM_SIZES];
    logic [VEC_W-1:0] cmp_mask;
    logic [VEC_W-1:0] sel_word;
    logic [VEC_W-1:0] nxt_data;
    logic             sum_set;
    logic             sum_clr;
    logic             rec_now;

    assign op   = op_e'(in_op);
    assign cond = cond_e'(in_cond);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        simd_elem_cmp #(
            .VEC_W (VEC_W),
            .EW    (BASE_EW << g)
        ) u_cmp (
            .a          (src_a),
            .b          (src_b),
            .gt_sel     (cond == CND_GT),
            .signed_sel (in_signed),
            .mask       (mask_by_size[g])
        );
    end

    assign cmp_mask = mask_by_size[size_index(in_size)];

    simd_bit_sel #(.VEC_W(VEC_W)) u_sel (
        .on_clr (src_a),
        .on_set (src_b),
        .sel    (src_m),
        .y      (sel_word)
    );

    simd_mask_summary #(.VEC_W(VEC_W)) u_sum (
        .mask    (cmp_mask),
        .all_set (sum_set),
        .all_clr (sum_clr)
    );

    always_comb begin
        unique case (op)
            OP_CMP:  nxt_data = cmp_mask;
            OP_SEL:  nxt_data = sel_word;
            default: nxt_data = '0;
        endcase
    end

    assign rec_now = in_valid && (op == OP_CMP) && in_rec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_all_true  <= 1'b0;
            out_all_false <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt_data;
            end
            if (rec_now) begin
                out_all_true  <= sum_set;
                out_all_false <= sum_clr;
            end
        end
    end
endmodule

// File: rtl/simd_cmpsel_chk.sv
`timescale 1ns/1ps
module simd_cmpsel_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_op,
    input logic             in_cond,
    input logic             in_signed,
    input logic [1:0]       in_size,
    input logic             in_rec,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] src_m,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data,
    input logic             out_all_true,
    input logic             out_all_false
);
    localparam int N_BYTES = VEC_W / 8;
    localparam int N_WORDS = VEC_W / 32;

    // R8: valid follows the request by one cycle
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R1: comparing a vector with itself for equality yields all ones
    p_eq_self_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !in_op && !in_cond && (src_a == src_b)) |-> (&out_data));

    // R5: select takes each bit from the mask-chosen source
    p_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_op) |->
            out_data == (($past(src_b) & $past(src_m)) | ($past(src_a) & ~$past(src_m))));

    // R6: recorded flags agree with the registered mask and never both set
    p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !in_op && in_rec) |->
            (out_all_true == (&out_data)) && (out_all_false == (~|out_data)));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_all_true && out_all_false));

    // R7: flags move only on a recorded compare
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(in_valid && !in_op && in_rec)) |->
            ($stable(out_all_true) && $stable(out_all_false)));

    // R8: output data holds while idle
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid) |-> $stable(out_data));

    for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
        // R4: byte-size compares produce whole-byte masks
        p_byte_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && !in_op && (in_size == 2'd0)) |->
                (out_data[j*8 +: 8] == 8'h00) || (out_data[j*8 +: 8] == 8'hFF));
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        // R4: word-size compares (codes 2 and 3) produce whole-word masks
        p_word_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && !in_op && in_size[1]) |->
                (out_data[w*32 +: 32] == 32'h0) || (out_data[w*32 +: 32] == 32'hFFFF_FFFF));
    end
endmodule

bind simd_cmpsel simd_cmpsel_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/simd_cmpsel_bench.sv
`timescale 1ns/1ps
module simd_cmpsel_bench;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_op = 1'b0;
    logic          in_cond = 1'b0;
    logic          in_signed = 1'b0;
    logic [1:0]    in_size = 2'd0;
    logic          in_rec = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [VW-1:0] src_m = '0;
    logic          out_valid;
    logic [VW-1:0] out_data;
    logic          out_all_true;
    logic          out_all_false;

    int nchk = 0;
    int nfail = 0;
    logic [VW-1:0] last_exp = '0;
    logic          exp_at = 1'b0;
    logic          exp_af = 1'b0;

    always #2.5 clk = ~clk;

    simd_cmpsel u_simd_cmpsel (.*);

    function automatic logic [VW-1:0] ref_cmp(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic [1:0] sz, input logic gt, input logic sg);
        logic [VW-1:0] r;
        int ew;
        r  = '0;
        ew = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        for (int e = 0; e < VW / ew; e++) begin
            longint va;
            longint vb;
            logic   t;
            va = 0;
            vb = 0;
            for (int k = 0; k < ew; k++) begin
                va[k] = a[e*ew+k];
                vb[k] = b[e*ew+k];
            end
            if (sg) begin
                if (va[ew-1]) va = va - (longint'(1) << ew);
                if (vb[ew-1]) vb = vb - (longint'(1) << ew);
            end
            t = gt ? (va > vb) : (va == vb);
            for (int k = 0; k < ew; k++) r[e*ew+k] = t;
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ref_sel(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic [VW-1:0] m);
        logic [VW-1:0] r;
        for (int i = 0; i < VW; i++) r[i] = m[i] ? b[i] : a[i];
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input logic ok, input string req, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic op, input logic gt, input logic sg, input logic [1:0] sz,
                          input logic rec, input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [VW-1:0] m, input string req);
        logic [VW-1:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_cond = gt; in_signed = sg; in_size = sz;
        in_rec = rec; src_a = a; src_b = b; src_m = m;
        e = op ? ref_sel(a, b, m) : ref_cmp(a, b, sz, gt, sg);
        if (!op && rec) begin
            exp_at = &e;
            exp_af = ~|e;
        end
        last_exp = e;
        @(negedge clk);
        check(out_valid == 1'b1, "R8", VW'(out_valid), VW'(1));
        check(out_data == e, req, out_data, e);
        check({out_all_true, out_all_false} == {exp_at, exp_af}, (!op && rec) ? "R6" : "R7",
              VW'({out_all_true, out_all_false}), VW'({exp_at, exp_af}));
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = rnd_vec(); src_b = rnd_vec(); src_m = rnd_vec();
        @(negedge clk);
        check(out_valid == 1'b0, "R8", VW'(out_valid), VW'(0));
        check(out_data == last_exp, "R8", out_data, last_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [VW-1:0] pix;
        logic [VW-1:0] msk;
        void'($urandom(32'd1234));

        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", VW'(out_valid), VW'(0));
        check(out_data == '0, "R9", out_data, '0);
        check({out_all_true, out_all_false} == 2'b00, "R9",
              VW'({out_all_true, out_all_false}), VW'(0));
        rst_n = 1'b1;

        // R1 then R5: zero bytes replaced with a fill value
        pix = 128'hC1_00_00_00_1A_1A_C1_1A_00_C1_00_00_1A_00_1A_C1;
        run_op(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, pix, '0, '0, "R1");
        msk = ref_cmp(pix, '0, 2'd0, 1'b0, 1'b0);
        check(out_data == 128'h00_FF_FF_FF_00_00_00_00_FF_00_FF_FF_00_FF_00_00, "R1",
              out_data, 128'h00_FF_FF_FF_00_00_00_00_FF_00_FF_FF_00_FF_00_00);
        run_op(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, pix, {16{8'h9A}}, msk, "R5");
        check(out_data == 128'hC1_9A_9A_9A_1A_1A_C1_1A_9A_C1_9A_9A_1A_9A_1A_C1, "R5",
              out_data, 128'hC1_9A_9A_9A_1A_1A_C1_1A_9A_C1_9A_9A_1A_9A_1A_C1);

        // R2 / R3: sign interpretation at 0x80 vs 0x7F
        run_op(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, {16{8'h80}}, {16{8'h7F}}, '0, "R2");
        check(out_all_false == 1'b1, "R2", VW'(out_all_false), VW'(1));
        run_op(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, {16{8'h80}}, {16{8'h7F}}, '0, "R3");
        check(out_all_true == 1'b1, "R3", VW'(out_all_true), VW'(1));

        // R7: unrecorded compare and select keep the all-true flag
        run_op(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, {16{8'h11}}, {16{8'h22}}, '0, "R1");
        run_op(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R5");
        check(out_all_true == 1'b1, "R7", VW'(out_all_true), VW'(1));

        // R4: halfword vs byte partition, and size code 3 aliasing words
        run_op(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, {8{16'h0100}}, {8{16'h00FF}}, '0, "R4");
        check(out_data == '1, "R4", out_data, '1);
        run_op(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, {8{16'h0100}}, {8{16'h00FF}}, '0, "R4");
        check(out_data == {8{16'hFF00}}, "R4", out_data, {8{16'hFF00}});
        run_op(1'b0, 1'b0, 1'b0, 2'd3, 1'b1, {32'h1, 32'h2, 32'h3, 32'h4},
               {32'h1, 32'h0, 32'h3, 32'h5}, '0, "R4");
        check(out_data == {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0}, "R4",
              out_data, {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0});

        idle_cycle();

        // Random mix, operands sharing many elements, back to back
        for (int i = 0; i < 400; i++) begin
            logic [VW-1:0] a;
            logic [VW-1:0] b;
            logic [1:0]    sz;
            logic          op;
            logic          gt;
            logic          sg;
            a  = rnd_vec();
            b  = ($urandom % 4 == 0) ? a : (a ^ (rnd_vec() & rnd_vec() & rnd_vec()));
            sz = 2'($urandom);
            op = ($urandom % 3 == 0);
            gt = 1'($urandom);
            sg = 1'($urandom);
            run_op(op, gt, sg, sz, 1'($urandom), a, b, rnd_vec(),
                   op ? "R5" : (!gt ? "R1" : (sg ? "R2" : "R3")));
            if (i % 50 == 7) idle_cycle();
        end

        // R9: reset clears flags and data again
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check({out_valid, out_all_true, out_all_false} == 3'b000 && out_data == '0, "R9",
              out_data, '0);

        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule